// File: doc/BRIEF.md
# Coarse Gain Search Sequencer

This block sequences the coarse part of a digitally tuned gain loop. A one-cycle start pulse begins a four-step successive-approximation search on a 4-bit gain code. Before each decision the block presets the peak and bottom amplitude detectors. It then waits a programmable number of settle cycles and samples the level comparator. The comparator reports "too large" and "too small". A 1 in any code bit means more gain.

The code is shown on its own port and also as a thermometer word, in which the lowest N bits are set for code value N. The block also drives a filter bandwidth select: wide while idle and while searching, narrow once the search is done. A mode output tells a downstream fine-tracking stage when it may take over.

A fresh start pulse in any mode restarts the search from the mid-scale trial.

Top module: `agc_search_seq`

## Requirements
- R1: Reset state. While `rst` is high and after it falls:
  - `mode_o` is IDLE (encoding 0) and `coarse_o` is 0.
  - `therm_o` is 0, `det_preset_o` is 1 and `narrow_bw_o` is 0.
  - IDLE holds without a start pulse, whatever the comparator flags do.
- R2: Start pulse. A clock edge that samples `start_i` high, in any mode, has these effects from the next cycle:
  - `mode_o` is SEARCH (encoding 1).
  - `coarse_o` is 4'b1000.
  - `det_preset_o` is 1 and `narrow_bw_o` is 0.
- R3: Decision timing.
  - Let S be `settle_i`, held steady during a search.
  - Decisions fall on the edges S+1, 2(S+1), 3(S+1) and 4(S+1) after the start edge, and nowhere else.
  - The fourth decision puts `mode_o` in TRACK (encoding 2).
- R4: Decision rule.
  - Decision k (k = 1..4) resolves bit 4-k of `coarse_o`. Bit 3 is the most significant bit.
  - The bit is cleared when `lg_i` is 1 and `sl_i` is 0. Otherwise it is kept. Both flags high counts as "keep".
  - Decisions 1 to 3 also set bit 3-k.
  - If the comparator reports "too large" exactly when the trial code exceeds a target T, the result is T.
- R5: `therm_o` always has exactly its lowest `coarse_o` bits set, and it changes in the same cycle as `coarse_o`.
- R6: Detector preset (`det_preset_o`).
  - It is 1 in the cycle after a start edge and in the cycle after every decision edge.
  - It is 0 in the other SEARCH cycles.
  - It is 1 throughout IDLE.
  - In TRACK it is 0 except for the cycle of entry.
- R7: `narrow_bw_o` is 1 exactly when `mode_o` is TRACK.
- R8: In TRACK, with no start pulse, `coarse_o`, `therm_o` and `mode_o` hold, whatever `lg_i` and `sl_i` do.
- R9: A start pulse in TRACK reloads 4'b1000 and runs a complete new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a coarse search |
| lg_i | input | 1 | Comparator flag: amplitude above upper threshold |
| sl_i | input | 1 | Comparator flag: amplitude below lower threshold |
| settle_i | input | 8 | Settle cycles between a detector preset and the next decision |
| coarse_o | output | 4 | Coarse gain code, 1 means more gain |
| therm_o | output | 16 | Thermometer form of the coarse code |
| det_preset_o | output | 1 | Preset request for both detectors (peak low, bottom high) |
| narrow_bw_o | output | 1 | Detector filter select: 0 wide-band, 1 narrow-band |
| mode_o | output | 2 | 0 IDLE, 1 SEARCH, 2 TRACK |

## Verification
A wrong step index or settle count shows up in two ways at the ports:
- the `det_preset_o` pulse train in SEARCH is off its S+1 grid from that step onward;
- the entry into TRACK happens one or more cycles early or late.

Both appear within one search, at most 4(S+1) cycles after start. A wrong bit update appears on `coarse_o` at the very next decision and carries through to the final code. The bench closes the loop with a comparator model driven from `coarse_o` against a target, so any such slip ends in a wrong final value. A thermometer fault or a code that drifts in TRACK appears in the first cycle after it happens.

// File: rtl/agc_seq_pkg.sv
package agc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SEARCH = 2'd1,
    MODE_TRACK  = 2'd2
  } agc_mode_e;
endpackage

// File: rtl/agc_step_timer.sv
// Settle counter: produces the search step strobe every (reload+1) cycles
module agc_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= reload_i;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= reload_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/agc_sar_reg.sv
// Successive-approximation register, MSB first, next bit pre-armed
module agc_sar_reg #(
  parameter int CODE_W = 4,
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              keep_i,
  output logic              last_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] code_nxt_o
);
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_q;
  int                pos;

  assign last_o = (idx_q == IDX_W'(CODE_W - 1));
  assign pos    = CODE_W - 1 - int'(idx_q);
  assign code_o = code_q;

  always_comb begin
    code_nxt_o = code_q;
    if (load_i) begin
      code_nxt_o = '0;
      code_nxt_o[CODE_W-1] = 1'b1;
    end else if (step_i) begin
      for (int b = 0; b < CODE_W; b++) begin
        if (b == pos)          code_nxt_o[b] = keep_i;
        else if (b + 1 == pos) code_nxt_o[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      idx_q  <= '0;
    end else begin
      code_q <= code_nxt_o;
      if (load_i)      idx_q <= '0;
      else if (step_i) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/agc_therm_enc.sv
// Binary to thermometer: output bit k is set when code exceeds k
module agc_therm_enc #(
  parameter int CODE_W = 4,
  localparam int THERM_W = 1 << CODE_W
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [THERM_W-1:0] therm_o
);
  for (genvar k = 0; k < THERM_W; k++) begin : g_bit
    assign therm_o[k] = (code_i > CODE_W'(k));
  end
endmodule

// File: rtl/agc_search_seq.sv
module agc_search_seq
  import agc_seq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SETTLE_W = 8,
  localparam int THERM_W = 1 << CODE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                lg_i,
  input  logic                sl_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [CODE_W-1:0]   coarse_o,
  output logic [THERM_W-1:0]  therm_o,
  output logic                det_preset_o,
  output logic                narrow_bw_o,
  output logic [1:0]          mode_o
);
  agc_mode_e          mode_q;
  logic               preset_q;
  logic               narrow_q;
  logic [THERM_W-1:0] therm_q;
  logic               searching;
  logic               step;
  logic               last;
  logic               keep;
  logic [CODE_W-1:0]  code_q;
  logic [CODE_W-1:0]  code_nxt;
  logic [THERM_W-1:0] therm_nxt;

  assign searching = (mode_q == MODE_SEARCH);
  // only a clean "too large" verdict removes gain
  assign keep      = ~(lg_i & ~sl_i);

  agc_step_timer #(.CNT_W(SETTLE_W)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .restart_i (start_i),
    .run_i     (searching),
    .reload_i  (settle_i),
    .step_o    (step)
  );

  agc_sar_reg #(.CODE_W(CODE_W)) sar_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .step_i     (step),
    .keep_i     (keep),
    .last_o     (last),
    .code_o     (code_q),
    .code_nxt_o (code_nxt)
  );

  agc_therm_enc #(.CODE_W(CODE_W)) enc_i (
    .code_i  (code_nxt),
    .therm_o (therm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IDLE;
      preset_q <= 1'b1;
      narrow_q <= 1'b0;
      therm_q  <= '0;
    end else begin
      therm_q <= therm_nxt;
      if (start_i) begin
        mode_q   <= MODE_SEARCH;
        preset_q <= 1'b1;
        narrow_q <= 1'b0;
      end else if (searching) begin
        preset_q <= step;
        if (step && last) begin
          mode_q   <= MODE_TRACK;
          narrow_q <= 1'b1;
        end
      end else begin
        preset_q <= (mode_q == MODE_IDLE);
      end
    end
  end

  assign coarse_o     = code_q;
  assign therm_o      = therm_q;
  assign det_preset_o = preset_q;
  assign narrow_bw_o  = narrow_q;
  assign mode_o       = mode_q;
endmodule

// File: rtl/agc_search_seq_chk.sv
module agc_search_seq_chk #(
  parameter int CODE_W = 4,
  localparam int THERM_W = 1 << CODE_W
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [CODE_W-1:0]  coarse_o,
  input logic [THERM_W-1:0] therm_o,
  input logic               det_preset_o,
  input logic               narrow_bw_o,
  input logic [1:0]         mode_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3); // R1
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0 && !start_i) |=> mode_o == 2'd0); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (mode_o == 2'd1 && coarse_o == MID && det_preset_o && !narrow_bw_o)); // R2
  AST_THERM_MATCH: assert property (@(posedge clk) disable iff (rst)
    therm_o == THERM_W'((64'd1 << coarse_o) - 64'd1)); // R5
  AST_IDLE_PRESET: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd0 |-> det_preset_o); // R6
  AST_TRACK_ENTRY_PRESET: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && $past(mode_o) == 2'd1) |-> det_preset_o); // R6
  AST_BW_SELECT: assert property (@(posedge clk) disable iff (rst)
    narrow_bw_o == (mode_o == 2'd2)); // R7
  AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && !start_i) |=> (mode_o == 2'd2 && $stable(coarse_o) && $stable(therm_o))); // R8
endmodule

bind agc_search_seq agc_search_seq_chk #(.CODE_W(CODE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .coarse_o     (coarse_o),
  .therm_o      (therm_o),
  .det_preset_o (det_preset_o),
  .narrow_bw_o  (narrow_bw_o),
  .mode_o       (mode_o)
);

// File: tb/agc_search_seq_tb_top.sv
`timescale 1ns/1ps
module agc_search_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        lg_i;
  logic        sl_i;
  logic [7:0]  settle_i = 8'd0;
  logic [3:0]  coarse_o;
  logic [15:0] therm_o;
  logic        det_preset_o;
  logic        narrow_bw_o;
  logic [1:0]  mode_o;

  int target = 0;
  bit both_hi = 1'b0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  // comparator model: too large when the trial code exceeds the target
  assign lg_i = both_hi ? 1'b1 : (int'(coarse_o) > target);
  assign sl_i = both_hi ? 1'b1 : (int'(coarse_o) < target);

  agc_search_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .lg_i(lg_i), .sl_i(sl_i),
    .settle_i(settle_i), .coarse_o(coarse_o), .therm_o(therm_o),
    .det_preset_o(det_preset_o), .narrow_bw_o(narrow_bw_o), .mode_o(mode_o)
  );

  function automatic int therm_of(int n);
    int t = 0;
    for (int k = 0; k < n; k++) t = t | (1 << k);
    return t;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_search(int t, int s, bit both, bit push);
    @(negedge clk);
    target   = t;
    settle_i = 8'(s);
    both_hi  = both;
    start_i  = 1'b1;
    if (push) exp_q.push_back(both ? 15 : t);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_track();
    while (mode_o != 2'd2) @(negedge clk);
  endtask

  task automatic skip(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: checks timing, preset grid and final code against the queue
  int  mcnt = 0;
  bit  pbad = 1'b0;
  bit  nbad = 1'b0;
  logic [1:0] prev_mode = 2'd0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!rst) begin
        if (start_i) begin
          mcnt = 0; pbad = 1'b0; nbad = 1'b0;
        end else begin
          mcnt++;
        end
        if (mode_o == 2'd1) begin
          if (det_preset_o != ((mcnt % (int'(settle_i) + 1)) == 0)) pbad = 1'b1;
          if (narrow_bw_o) nbad = 1'b1;
        end
        if (mode_o == 2'd2 && prev_mode != 2'd2) begin
          int e;
          if (exp_q.size() == 0) begin
            check("R3 unexpected track entry", 1, 0);
          end else begin
            e = exp_q.pop_front();
            check("R4 final coarse", int'(coarse_o), e);
            check("R5 final therm", int'(therm_o), therm_of(e));
            check("R3 cycles to track", mcnt, 4 * (int'(settle_i) + 1));
            check("R6 preset grid in search", int'(pbad), 0);
            check("R6 preset on track entry", int'(det_preset_o), 1);
            check("R7 narrow in track / wide in search", int'({nbad, narrow_bw_o}), 1);
          end
        end
      end
      prev_mode = mode_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    skip(3);
    check("R1 reset mode", int'(mode_o), 0);
    check("R1 reset coarse", int'(coarse_o), 0);
    check("R1 reset therm", int'(therm_o), 0);
    check("R1 reset preset", int'(det_preset_o), 1);
    check("R1 reset narrow", int'(narrow_bw_o), 0);
    @(negedge clk); rst = 1'b0;
    target = 15; skip(4); target = 0; both_hi = 1'b1; skip(4); both_hi = 1'b0;
    check("R1 idle holds mode", int'(mode_o), 0);
    check("R6 idle preset", int'(det_preset_o), 1);

    // R2 and R4 step by step, target 5, settle 2
    start_search(5, 2, 1'b0, 1'b1);
    check("R2 start mode", int'(mode_o), 1);
    check("R2 start coarse", int'(coarse_o), 8);
    check("R2 start preset", int'(det_preset_o), 1);
    check("R5 start therm", int'(therm_o), 16'h00FF);
    skip(1);
    check("R6 preset low while settling", int'(det_preset_o), 0);
    skip(2);
    check("R4 step1 clears b1 arms b2", int'(coarse_o), 4'b0100);
    check("R5 step1 therm", int'(therm_o), 16'h000F);
    skip(3);
    check("R4 step2 keeps b2 arms b3", int'(coarse_o), 4'b0110);
    skip(3);
    check("R4 step3 clears b3 arms b4", int'(coarse_o), 4'b0101);
    wait_track();

    // R8: flags ignored in TRACK
    skip(2);
    target = 0; skip(5); target = 15; skip(5); both_hi = 1'b1; skip(5); both_hi = 1'b0;
    check("R8 track coarse held", int'(coarse_o), 5);
    check("R8 track therm held", int'(therm_o), therm_of(5));
    check("R8 track mode held", int'(mode_o), 2);
    check("R6 track preset low", int'(det_preset_o), 0);

    // R9: restart from TRACK, then boundaries and varied settle
    start_search(0, 0, 1'b0, 1'b1);
    check("R9 restart coarse", int'(coarse_o), 8);
    check("R9 restart narrow", int'(narrow_bw_o), 0);
    wait_track();
    skip(2);
    start_search(15, 3, 1'b0, 1'b1); wait_track(); skip(2);
    start_search(10, 1, 1'b0, 1'b1); wait_track(); skip(2);
    start_search(7, 5, 1'b0, 1'b1);  wait_track(); skip(2);
    start_search(8, 0, 1'b0, 1'b1);  wait_track(); skip(2);
    // R4: both flags high counts as keep
    start_search(0, 1, 1'b1, 1'b1);  wait_track(); skip(2);
    both_hi = 1'b0;
    // R2: restart in mid-search, only the second search completes
    start_search(3, 4, 1'b0, 1'b0);
    skip(7);
    start_search(12, 2, 1'b0, 1'b1);
    check("R2 mid-search restart coarse", int'(coarse_o), 8);
    wait_track(); skip(3);
    check("R3 all searches completed", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule